// File: doc/BRIEF.md
# Branch and jump target generator

This block produces the next instruction address for a 32-bit processor whose instructions are all four bytes long and always word aligned. Each cycle it takes the current instruction address, the 16-bit signed word offset of a conditional branch, the 26-bit word index of a direct jump, and the two register operands of a branch. It also takes a small control code that the decoder has already chosen. From these it forms the sequential address, the branch target and the jump target. It evaluates the branch condition and selects the next address.

Both targets are reported on every valid result, whether or not they are chosen, so that a later stage can use them for prediction checks or for tracing. Results are registered and appear one clock after the request. A valid flag travels with them.

The branch condition tests the first operand against the second for equality or inequality, or tests the first operand as a signed value against zero. A less-than test between two registers is not formed here. A separate set-less-than result is fed in as an operand and compared against a zero register with the equality kinds. This avoids the overflow that a subtraction-based compare would suffer.

Top module: `pctgt_next`

## Requirements
- R1: While `rst_ni` is low and after its release, until the first request is captured, `valid_o`, `taken_o`, `next_pc_o`, `br_target_o` and `jmp_target_o` are all zero.
- R2: Control code 0 (sequential) gives `next_pc_o` = `pc_i` + 4 modulo 2^32 and `taken_o` = 0. From 0xFFFFFFFC it gives 0x00000000.
- R3: `br_target_o` = `pc_i` + 4 + (`ofs_i` sign-extended to 32 bits, shifted left by 2), modulo 2^32. The byte displacement from `pc_i` + 4 therefore spans -131072 to +131068.
- R4: `jmp_target_o` = {bits 31:28 of (`pc_i` + 4), `jidx_i`, 2'b00}. The upper bits therefore come from the following instruction's address, which matters when `pc_i` = 0x0FFFFFFC.
- R5: Code 1 branches when `rs_val_i` == `rt_val_i`. Code 2 branches when they differ. All 32 bits are compared.
- R6: Code 3 branches when bit 31 of `rs_val_i` is 1. Code 4 branches when bit 31 is 0. `rt_val_i` has no effect on either.
- R7: Code 5 branches when `rs_val_i` is zero or negative as a signed value. Code 6 branches when it is strictly positive. `rt_val_i` has no effect on either.
- R8: A taken branch gives `next_pc_o` = `br_target_o` and `taken_o` = 1. A branch whose condition is false gives `next_pc_o` = `pc_i` + 4 and `taken_o` = 0.
- R9: A request with `valid_i` = 1 at a rising edge shows its results with `valid_o` = 1 after that edge, for exactly one cycle. `valid_o` is 0 after any edge at which `valid_i` was 0.
- R10: Code 7 (jump) always gives `taken_o` = 1 and `next_pc_o` = `jmp_target_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| flow_i | input | 3 | Control code: 0 seq, 1 eq, 2 ne, 3 neg, 4 non-neg, 5 non-pos, 6 pos, 7 jump |
| pc_i | input | 32 | Address of the current instruction |
| ofs_i | input | 16 | Signed branch offset in words |
| jidx_i | input | 26 | Jump word index |
| rs_val_i | input | 32 | First branch operand |
| rt_val_i | input | 32 | Second branch operand (equality kinds only) |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch or jump taken |
| next_pc_o | output | 32 | Selected next instruction address |
| br_target_o | output | 32 | Computed branch target |
| jmp_target_o | output | 32 | Computed jump target |

## Verification
Almost all of this block is combinational ahead of one register stage. A wrong value inside the block shows at the ports one cycle after the request that exposed it, and there is no hidden state to carry the error further. The corner values drive each internal path to its limit:
- sign-extension errors show as a branch target off by 2^18 for the most negative offset;
- a wrong source for the jump segment shows only at 0x0FFFFFFC;
- a broken zero or sign detect shows as the wrong `taken_o` for zero, 0x80000000 and 1.

A stuck or mis-timed valid register shows either as a result that never arrives or as an unexpected one while the block is idle.

// File: rtl/pctgt_pkg.sv
package pctgt_pkg;
  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BEQ  = 3'd1,
    FLOW_BNE  = 3'd2,
    FLOW_BLTZ = 3'd3,
    FLOW_BGEZ = 3'd4,
    FLOW_BLEZ = 3'd5,
    FLOW_BGTZ = 3'd6,
    FLOW_JUMP = 3'd7
  } flow_e;
endpackage

// File: rtl/pctgt_cond.sv
module pctgt_cond
  import pctgt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e            flow_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  output logic             take_o
);
  logic same, neg, zero;

  assign same = (rs_i == rt_i);
  assign neg  = rs_i[XLEN-1];
  assign zero = ~|rs_i;

  always_comb begin
    unique case (flow_i)
      FLOW_BEQ:  take_o = same;
      FLOW_BNE:  take_o = !same;
      FLOW_BLTZ: take_o = neg;
      FLOW_BGEZ: take_o = !neg;
      FLOW_BLEZ: take_o = neg | zero;
      FLOW_BGTZ: take_o = !neg & !zero;
      FLOW_JUMP: take_o = 1'b1;
      default:   take_o = 1'b0;
    endcase
  end

  // R7: non-positive and positive tests are exact complements
  always_comb begin
    if (flow_i == FLOW_BGTZ && take_o)
      p_pos_nonzero_r7: assert ($signed(rs_i) > 0);
  end
endmodule

// File: rtl/pctgt_addr.sv
module pctgt_addr #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int JMP_W = 26,
  parameter int ALIGN = 2
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [JMP_W-1:0] jidx_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o,
  output logic [XLEN-1:0]  jmp_o
);
  localparam int SEG_W = XLEN - JMP_W - ALIGN;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

  logic [XLEN-1:0] ofs_ext;

  assign seq_o   = pc_i + STEP;
  assign ofs_ext = {{(XLEN-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign br_o    = seq_o + (ofs_ext << ALIGN);

  generate
    if (SEG_W > 0) begin : g_seg
      // segment bits come from the following instruction's address
      assign jmp_o = {seq_o[XLEN-1 -: SEG_W], jidx_i, {ALIGN{1'b0}}};
    end else begin : g_flat
      assign jmp_o = {jidx_i[XLEN-ALIGN-1:0], {ALIGN{1'b0}}};
    end
  endgenerate

  // R3: word alignment of pc carries into the branch target
  always_comb begin
    p_br_align_r3: assert (br_o[ALIGN-1:0] == pc_i[ALIGN-1:0]);
  end
endmodule

// File: rtl/pctgt_next.sv
module pctgt_next
  import pctgt_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int JMP_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       flow_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [JMP_W-1:0] jidx_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  output logic             valid_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  br_target_o,
  output logic [XLEN-1:0]  jmp_target_o
);
  localparam int ALIGN = 2;

  flow_e           flow;
  logic            take;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, sel_pc;

  assign flow = flow_e'(flow_i);

  pctgt_addr #(.XLEN(XLEN), .OFS_W(OFS_W), .JMP_W(JMP_W), .ALIGN(ALIGN)) i_addr (
    .pc_i   (pc_i),
    .ofs_i  (ofs_i),
    .jidx_i (jidx_i),
    .seq_o  (seq_pc),
    .br_o   (br_pc),
    .jmp_o  (jmp_pc)
  );

  pctgt_cond #(.XLEN(XLEN)) i_cond (
    .flow_i (flow),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .take_o (take)
  );

  always_comb begin
    if (!take)                  sel_pc = seq_pc;
    else if (flow == FLOW_JUMP) sel_pc = jmp_pc;
    else                        sel_pc = br_pc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      taken_o      <= 1'b0;
      next_pc_o    <= '0;
      br_target_o  <= '0;
      jmp_target_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o      <= take;
        next_pc_o    <= sel_pc;
        br_target_o  <= br_pc;
        jmp_target_o <= jmp_pc;
      end
    end
  end

  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && flow_i == 3'd0 |=> !taken_o && next_pc_o == $past(pc_i) + XLEN'(4));

  p_eq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && flow_i == 3'd1 |=> taken_o == ($past(rs_val_i) == $past(rt_val_i)));

  p_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && flow_i == 3'd3 |=> taken_o == $past(rs_val_i[XLEN-1]));

  p_select_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && flow_i != 3'd0 && flow_i != 3'd7
    |=> next_pc_o == (taken_o ? br_target_o : $past(pc_i) + XLEN'(4)));

  p_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_jump_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && flow_i == 3'd7 |=> taken_o && next_pc_o == jmp_target_o);
endmodule

// File: tb/test_pctgt_next.sv
`timescale 1ns/1ps
module test_pctgt_next;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  flow_i = '0;
  logic [31:0] pc_i = '0;
  logic [15:0] ofs_i = '0;
  logic [25:0] jidx_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic        valid_o, taken_o;
  logic [31:0] next_pc_o, br_target_o, jmp_target_o;

  int total = 0;
  int bad = 0;

  logic [31:0] q_npc[$], q_br[$], q_jt[$];
  logic        q_tk[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  pctgt_next i_pctgt_next (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .flow_i(flow_i),
    .pc_i(pc_i), .ofs_i(ofs_i), .jidx_i(jidx_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .br_target_o(br_target_o), .jmp_target_o(jmp_target_o)
  );

  task automatic issue(input logic [2:0] f, input logic [31:0] pc, input logic [15:0] o,
                       input logic [25:0] j, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [31:0] seq, br, jt;
    logic tk;
    @(negedge clk);
    valid_i = 1'b1; flow_i = f; pc_i = pc; ofs_i = o; jidx_i = j;
    rs_val_i = a; rt_val_i = b;
    seq = pc + 32'd4;
    br  = seq + {{14{o[15]}}, o, 2'b00};
    jt  = {seq[31:28], j, 2'b00};
    case (f)
      3'd1: tk = (a == b);
      3'd2: tk = (a != b);
      3'd3: tk = ($signed(a) < 0);
      3'd4: tk = ($signed(a) >= 0);
      3'd5: tk = ($signed(a) <= 0);
      3'd6: tk = ($signed(a) > 0);
      3'd7: tk = 1'b1;
      default: tk = 1'b0;
    endcase
    q_tk.push_back(tk);
    q_npc.push_back(!tk ? seq : (f == 3'd7 ? jt : br));
    q_br.push_back(br);
    q_jt.push_back(jt);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // monitor: pops one expectation per valid result
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      total++;
      if (q_tk.size() == 0) begin
        bad++;
        $display("FAIL R9: unexpected valid_o=1, expected 0");
      end else begin
        logic tk;
        logic [31:0] npc, br, jt;
        string tag;
        tk = q_tk.pop_front(); npc = q_npc.pop_front();
        br = q_br.pop_front(); jt = q_jt.pop_front(); tag = q_tag.pop_front();
        if (taken_o !== tk || next_pc_o !== npc || br_target_o !== br || jmp_target_o !== jt) begin
          bad++;
          $display("FAIL %s: got tk=%0b npc=%h br=%h jt=%h exp tk=%0b npc=%h br=%h jt=%h",
                   tag, taken_o, next_pc_o, br_target_o, jmp_target_o, tk, npc, br, jt);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || taken_o !== 1'b0 || next_pc_o !== 32'd0 ||
        br_target_o !== 32'd0 || jmp_target_o !== 32'd0) begin
      bad++;
      $display("FAIL R1: reset outputs v=%0b t=%0b npc=%h br=%h jt=%h expected all zero",
               valid_o, taken_o, next_pc_o, br_target_o, jmp_target_o);
    end
    rst_ni = 1'b1;
    idle(2);
    total++;
    if (valid_o !== 1'b0 || next_pc_o !== 32'd0) begin
      bad++;
      $display("FAIL R1: after release v=%0b npc=%h expected 0 0", valid_o, next_pc_o);
    end

    // R2 sequential, including wrap
    issue(3'd0, 32'h0040_0000, 16'h0010, 26'h0, 32'd0, 32'd0, "R2");
    issue(3'd0, 32'hFFFF_FFFC, 16'h0000, 26'h0, 32'd0, 32'd0, "R2 wrap");
    // R3 offset extremes
    issue(3'd1, 32'h0040_0100, 16'h7FFF, 26'h0, 32'd5, 32'd5, "R3 max ofs");
    issue(3'd1, 32'h0040_0100, 16'h8000, 26'h0, 32'd5, 32'd5, "R3 min ofs");
    issue(3'd1, 32'h0000_0010, 16'hFFF0, 26'h0, 32'd1, 32'd1, "R3 wrap low");
    // R4 / R10 jump, segment boundary
    issue(3'd7, 32'h0FFF_FFFC, 16'h0, 26'h123_4567, 32'd0, 32'd0, "R4 seg boundary");
    issue(3'd7, 32'hA000_0000, 16'h0, 26'h3FF_FFFF, 32'd0, 32'd0, "R10 jump");
    // R5 equality
    issue(3'd1, 32'h100, 16'h4, 26'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R5 beq ne");
    issue(3'd2, 32'h100, 16'h4, 26'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R5 bne taken");
    issue(3'd2, 32'h100, 16'h4, 26'h0, 32'h8000_0000, 32'h8000_0000, "R5 bne eq");
    // R6 sign, rt ignored
    issue(3'd3, 32'h200, 16'hFFFE, 26'h0, 32'h8000_0000, 32'h0, "R6 bltz neg");
    issue(3'd3, 32'h200, 16'hFFFE, 26'h0, 32'h0, 32'hFFFF_FFFF, "R6 bltz zero");
    issue(3'd4, 32'h200, 16'h0003, 26'h0, 32'h0, 32'h8000_0000, "R6 bgez zero");
    issue(3'd4, 32'h200, 16'h0003, 26'h0, 32'hFFFF_FFFF, 32'h0, "R6 bgez neg");
    // R7 zero-aware tests
    issue(3'd5, 32'h300, 16'h0008, 26'h0, 32'h0, 32'h1, "R7 blez zero");
    issue(3'd5, 32'h300, 16'h0008, 26'h0, 32'h1, 32'h0, "R7 blez pos");
    issue(3'd6, 32'h300, 16'h0008, 26'h0, 32'h0, 32'h5, "R7 bgtz zero");
    issue(3'd6, 32'h300, 16'h0008, 26'h0, 32'h1, 32'h0, "R7 bgtz one");
    issue(3'd6, 32'h300, 16'h0008, 26'h0, 32'h8000_0000, 32'h0, "R7 bgtz min");
    issue(3'd6, 32'h300, 16'h0008, 26'h0, 32'h7FFF_FFFF, 32'h0, "R7 bgtz max");
    // R9 gap then single result
    idle(3);
    issue(3'd0, 32'h1000, 16'h0, 26'h0, 32'd0, 32'd0, "R9 single");
    idle(3);

    // R8 mixed traffic
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (k % 3 == 0) ? a : $urandom;
      if (k % 7 == 0) a = 32'd0;
      issue(3'($urandom), {$urandom} & 32'hFFFF_FFFC, 16'($urandom), 26'($urandom), a, b, "R8 mixed");
      if (k % 11 == 0) idle(1);
    end
    idle(4);
    total++;
    if (q_tk.size() != 0) begin
      bad++;
      $display("FAIL R9: %0d results missing, expected 0", q_tk.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule